// File: doc/BRIEF.md
# Three-Stage Pipelined Register ALU Datapath

This block is the execution core of a small microcoded machine. It holds a set of 32-bit working registers and runs one micro-operation per clock through three stages. Each stage is bounded by latches on the buses. In the first stage, one register is driven onto the A bus and a decoded source is driven onto the B bus, and both are captured in the operand latches. In the second stage, the ALU and then the shifter act on the latched operands, and the result and its flags are captured in the result latch. In the third stage, the result latch is written into every register named by a destination mask. The same latch contents are shown on the write-back outputs.

A controller offers a micro-operation with `uop_valid`. It is consumed on any rising edge where `uop_ready` is also high. The micro-operation carries an A register index, a 4-bit encoded B source, an ALU function, a shift control and a destination mask. An external operand word (`ext_data`) is one of the B sources, so constants and memory data can enter the register set. The block has no forwarding paths. When an offered micro-operation reads a register that an accepted but unfinished micro-operation will write, `uop_ready` drops and bubbles enter the pipeline until the write has landed. The release of `rst_n` must be synchronous to `clk`.

Top module: `dp3_pipe3`

## Requirements
- R1: After reset all working registers read as zero, `wb_valid` is low, and `uop_ready` is high for any offered micro-operation.
- R2: A micro-operation accepted on edge n shows its result on `wb_data`/`wb_dest`, with `wb_valid` high, during the single cycle after edge n+1. Its register write lands on edge n+2, and `wb_valid` is never high without such an acceptance.
- R3: ALU function codes on `uop_op`: 0 is A+B, 1 is A-B, 2 is A AND B, 3 is A OR B, 4 is B+1, 5 is B-1, 6 passes A, and 7 passes B. Arithmetic wraps modulo 2^32.
- R4: The shifter acts on the ALU output. `uop_shift` code 1 shifts left logically by 8 bits, code 2 shifts right arithmetically by 1 bit, and codes 0 and 3 leave the value unchanged.
- R5: B source codes on `uop_bsel`: codes 0 to 7 select register 0 to 7, code 8 selects `ext_data` as sampled on the accepting edge, and codes 9 to 15 drive zero.
- R6: `wb_zero` is high exactly when the shifted result is zero, and `wb_neg` equals bit 31 of the shifted result.
- R7: Bit i of `uop_dest` writes register i. Any number of bits may be set, and a zero mask writes nothing.
- R8: Micro-operations with no pending read-after-write dependence are accepted on consecutive edges, and their results appear on consecutive cycles.
- R9: `uop_ready` is low while a used source register is the destination of a micro-operation accepted on either of the two previous edges. A dependent directly behind its producer waits two cycles, and a dependent with one independent micro-operation between them waits one cycle. In both cases it reads the producer's value.
- R10: Only used operands count as hazards. Codes 4, 5 and 7 ignore the A index, code 6 ignores the B source, and B codes 8 to 15 never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | A micro-operation is offered |
| uop_ready | output | 1 | The offered micro-operation is taken on this edge |
| uop_asel | input | 3 | A bus register index |
| uop_bsel | input | 4 | Encoded B bus source |
| uop_op | input | 3 | ALU function code |
| uop_shift | input | 2 | Shifter control |
| uop_dest | input | 8 | Destination register mask |
| ext_data | input | 32 | External operand word on B source code 8 |
| wb_valid | output | 1 | Result latch holds a micro-operation |
| wb_dest | output | 8 | Destination mask being written |
| wb_data | output | 32 | Result being written |
| wb_zero | output | 1 | Result is zero |
| wb_neg | output | 1 | Result is negative |

## Verification
The ALU and shifter are tested on two fixed, unequal register operands and on a word that has its sign bit set and a low nibble bit set. These values separate each function code from its neighbours and show whether the shift fills with zeros or with the sign. Issue behaviour is tested with three patterns: a stream of independent micro-operations, a dependent directly behind its producer, and a dependent with one independent micro-operation between them. The different stall lengths show whether each pipeline stage is checked on its own and whether a write has really landed before the read. Further micro-operations name an in-flight destination only in a field the function ignores. These show any false stalls, and a final positive control confirms that a real dependence is still caught.

// File: rtl/dp3_pkg.sv
package dp3_pkg;

  typedef enum logic [2:0] {
    ALU_ADD   = 3'd0,
    ALU_SUB   = 3'd1,
    ALU_AND   = 3'd2,
    ALU_OR    = 3'd3,
    ALU_INCB  = 3'd4,
    ALU_DECB  = 3'd5,
    ALU_PASSA = 3'd6,
    ALU_PASSB = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_SLL8 = 2'd1,
    SH_SRA1 = 2'd2,
    SH_RSVD = 2'd3
  } shift_e;

  function automatic logic op_reads_a(alu_op_e op);
    return !(op == ALU_INCB || op == ALU_DECB || op == ALU_PASSB);
  endfunction

  function automatic logic op_reads_b(alu_op_e op);
    return op != ALU_PASSA;
  endfunction

endpackage

// File: rtl/dp3_regfile.sv
module dp3_regfile #(
  parameter int W      = 32,
  parameter int NREG   = 8,
  parameter int BSEL_W = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       rd_a_idx,
  output logic [W-1:0]        rd_a_data,
  input  logic [BSEL_W-1:0]   rd_b_sel,
  input  logic [W-1:0]        ext_data,
  output logic [W-1:0]        rd_b_data,
  input  logic                wr_en,
  input  logic [NREG-1:0]     wr_mask,
  input  logic [W-1:0]        wr_data
);

  localparam int EXT_CODE = NREG;

  logic [NREG-1:0][W-1:0] rf_q;
  logic [NREG-1:0]        b_onehot;
  logic                   b_ext;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [W-1:0] q;
    logic         we;
    assign we = wr_en & wr_mask[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we) begin
        q <= wr_data;
      end
    end
    assign rf_q[i]     = q;
    assign b_onehot[i] = (rd_b_sel == BSEL_W'(i));
  end

  assign b_ext = (rd_b_sel == BSEL_W'(EXT_CODE));

  always_comb begin
    rd_a_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_a_idx == AW'(i)) rd_a_data = rd_a_data | rf_q[i];
    end
  end

  always_comb begin
    rd_b_data = b_ext ? ext_data : '0;
    for (int i = 0; i < NREG; i++) begin
      if (b_onehot[i]) rd_b_data = rd_b_data | rf_q[i];
    end
  end

endmodule

// File: rtl/dp3_alu_shift.sv
module dp3_alu_shift
  import dp3_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  input  shift_e       shift,
  output logic [W-1:0] result,
  output logic         is_zero,
  output logic         is_neg
);

  logic [W-1:0] alu_out;

  always_comb begin
    case (op)
      ALU_ADD:   alu_out = opa + opb;
      ALU_SUB:   alu_out = opa - opb;
      ALU_AND:   alu_out = opa & opb;
      ALU_OR:    alu_out = opa | opb;
      ALU_INCB:  alu_out = opb + W'(1);
      ALU_DECB:  alu_out = opb - W'(1);
      ALU_PASSA: alu_out = opa;
      default:   alu_out = opb;
    endcase
  end

  always_comb begin
    case (shift)
      SH_SLL8: result = {alu_out[W-9:0], 8'h00};
      SH_SRA1: result = {alu_out[W-1], alu_out[W-1:1]};
      default: result = alu_out;
    endcase
  end

  assign is_zero = (result == '0);
  assign is_neg  = result[W-1];

endmodule

// File: rtl/dp3_hazard.sv
module dp3_hazard
  import dp3_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int BSEL_W = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic [AW-1:0]     asel,
  input  logic [BSEL_W-1:0] bsel,
  input  alu_op_e           op,
  input  logic              s1_valid,
  input  logic [NREG-1:0]   s1_dest,
  input  logic              s2_valid,
  input  logic [NREG-1:0]   s2_dest,
  output logic              stall
);

  logic [NREG-1:0] src_mask;
  logic [NREG-1:0] busy_mask;

  always_comb begin
    src_mask = '0;
    for (int i = 0; i < NREG; i++) begin
      if (op_reads_a(op) && asel == AW'(i))     src_mask[i] = 1'b1;
      if (op_reads_b(op) && bsel == BSEL_W'(i)) src_mask[i] = 1'b1;
    end
  end

  assign busy_mask = ({NREG{s1_valid}} & s1_dest) | ({NREG{s2_valid}} & s2_dest);
  assign stall     = |(src_mask & busy_mask);

endmodule

// File: rtl/dp3_pipe3.sv
module dp3_pipe3
  import dp3_pkg::*;
#(
  parameter int W      = 32,
  parameter int NREG   = 8,
  parameter int BSEL_W = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uop_valid,
  output logic              uop_ready,
  input  logic [AW-1:0]     uop_asel,
  input  logic [BSEL_W-1:0] uop_bsel,
  input  logic [2:0]        uop_op,
  input  logic [1:0]        uop_shift,
  input  logic [NREG-1:0]   uop_dest,
  input  logic [W-1:0]      ext_data,
  output logic              wb_valid,
  output logic [NREG-1:0]   wb_dest,
  output logic [W-1:0]      wb_data,
  output logic              wb_zero,
  output logic              wb_neg
);

  // operand latch stage (A and B bus latches)
  logic            s1_valid_q, s1_valid_d;
  logic [W-1:0]    s1_a_q, s1_b_q;
  alu_op_e         s1_op_q;
  shift_e          s1_shift_q;
  logic [NREG-1:0] s1_dest_q;
  logic            s1_en;

  // result latch stage (C bus latch)
  logic            s2_valid_q, s2_valid_d;
  logic [W-1:0]    s2_data_q;
  logic            s2_zero_q, s2_neg_q;
  logic [NREG-1:0] s2_dest_q;
  logic            s2_en;

  logic [W-1:0]    a_bus, b_bus, c_bus;
  logic            c_zero, c_neg;
  logic            stall, accept;
  alu_op_e         in_op;

  assign in_op = alu_op_e'(uop_op);

  dp3_regfile #(.W(W), .NREG(NREG), .BSEL_W(BSEL_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (uop_asel),
    .rd_a_data (a_bus),
    .rd_b_sel  (uop_bsel),
    .ext_data  (ext_data),
    .rd_b_data (b_bus),
    .wr_en     (s2_valid_q),
    .wr_mask   (s2_dest_q),
    .wr_data   (s2_data_q)
  );

  dp3_hazard #(.NREG(NREG), .BSEL_W(BSEL_W)) u_hz (
    .asel     (uop_asel),
    .bsel     (uop_bsel),
    .op       (in_op),
    .s1_valid (s1_valid_q),
    .s1_dest  (s1_dest_q),
    .s2_valid (s2_valid_q),
    .s2_dest  (s2_dest_q),
    .stall    (stall)
  );

  dp3_alu_shift #(.W(W)) u_alu (
    .opa     (s1_a_q),
    .opb     (s1_b_q),
    .op      (s1_op_q),
    .shift   (s1_shift_q),
    .result  (c_bus),
    .is_zero (c_zero),
    .is_neg  (c_neg)
  );

  // next-state
  always_comb begin
    accept     = uop_valid & ~stall;
    s1_en      = accept;
    s1_valid_d = accept;
    s2_en      = s1_valid_q;
    s2_valid_d = s1_valid_q;
  end

  // valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
    end
  end

  // operand latches, loaded only on issue
  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_a_q     <= a_bus;
      s1_b_q     <= b_bus;
      s1_op_q    <= in_op;
      s1_shift_q <= shift_e'(uop_shift);
      s1_dest_q  <= uop_dest;
    end
  end

  // result latch, loaded only when the operand stage holds work
  always_ff @(posedge clk) begin
    if (s2_en) begin
      s2_data_q <= c_bus;
      s2_zero_q <= c_zero;
      s2_neg_q  <= c_neg;
      s2_dest_q <= s1_dest_q;
    end
  end

  assign uop_ready = ~stall;
  assign wb_valid  = s2_valid_q;
  assign wb_dest   = s2_dest_q;
  assign wb_data   = s2_data_q;
  assign wb_zero   = s2_zero_q;
  assign wb_neg    = s2_neg_q;

endmodule

// File: rtl/dp3_pipe3_chk.sv
module dp3_pipe3_chk #(
  parameter int W      = 32,
  parameter int NREG   = 8,
  parameter int BSEL_W = 4,
  localparam int AW    = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uop_valid,
  input logic              uop_ready,
  input logic [AW-1:0]     uop_asel,
  input logic [BSEL_W-1:0] uop_bsel,
  input logic [2:0]        uop_op,
  input logic [NREG-1:0]   uop_dest,
  input logic              wb_valid,
  input logic [W-1:0]      wb_data,
  input logic              wb_zero,
  input logic              wb_neg
);

  logic            took;
  logic [NREG-1:0] fly1, fly2;
  logic [NREG-1:0] need;
  logic            a_used, b_used;

  assign took   = rst_n & uop_valid & uop_ready;
  assign a_used = (uop_op != 3'd4) && (uop_op != 3'd5) && (uop_op != 3'd7);
  assign b_used = (uop_op != 3'd6);

  always_comb begin
    need = '0;
    if (a_used) need[uop_asel] = 1'b1;
    if (b_used && uop_bsel < BSEL_W'(NREG)) need[uop_bsel[AW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fly1 <= '0;
      fly2 <= '0;
    end else begin
      fly1 <= took ? uop_dest : '0;
      fly2 <= fly1;
    end
  end

  // R2
  issue_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> ##1 wb_valid);

  // R2
  wb_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(took, 2));

  // R9
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (need & (fly1 | fly2)) != '0) |-> !uop_ready);

  // R8
  free_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (need & (fly1 | fly2)) == '0) |-> uop_ready);

  // R6
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_zero == (wb_data == '0)) && (wb_neg == wb_data[W-1]));

endmodule

bind dp3_pipe3 dp3_pipe3_chk #(.W(W), .NREG(NREG), .BSEL_W(BSEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .uop_valid (uop_valid),
  .uop_ready (uop_ready),
  .uop_asel  (uop_asel),
  .uop_bsel  (uop_bsel),
  .uop_op    (uop_op),
  .uop_dest  (uop_dest),
  .wb_valid  (wb_valid),
  .wb_data   (wb_data),
  .wb_zero   (wb_zero),
  .wb_neg    (wb_neg)
);

// File: tb/sim_dp3_pipe3.sv
`timescale 1ns/1ps
module sim_dp3_pipe3;

  localparam int OP_ADD = 0, OP_SUB = 1, OP_AND = 2, OP_OR = 3;
  localparam int OP_INCB = 4, OP_DECB = 5, OP_PASSA = 6, OP_PASSB = 7;
  localparam int B_EXT = 8, B_ZERO = 9;
  localparam logic [31:0] V1 = 32'h1234_5678;
  localparam logic [31:0] V2 = 32'h0000_F00F;

  logic        clk, rst_n;
  logic        uop_valid, uop_ready;
  logic [2:0]  uop_asel;
  logic [3:0]  uop_bsel;
  logic [2:0]  uop_op;
  logic [1:0]  uop_shift;
  logic [7:0]  uop_dest;
  logic [31:0] ext_data;
  logic        wb_valid;
  logic [7:0]  wb_dest;
  logic [31:0] wb_data;
  logic        wb_zero, wb_neg;

  int checks = 0;
  int errors = 0;

  dp3_pipe3 u0 (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_asel(uop_asel), .uop_bsel(uop_bsel), .uop_op(uop_op),
    .uop_shift(uop_shift), .uop_dest(uop_dest), .ext_data(ext_data),
    .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data),
    .wb_zero(wb_zero), .wb_neg(wb_neg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put(input int a, input int b, input int op, input int sh,
                     input int mask, input logic [31:0] x);
    uop_valid = 1'b1;
    uop_asel  = 3'(a);
    uop_bsel  = 4'(b);
    uop_op    = 3'(op);
    uop_shift = 2'(sh);
    uop_dest  = 8'(mask);
    ext_data  = x;
  endtask

  task automatic idle();
    uop_valid = 1'b0;
    uop_dest  = 8'h00;
  endtask

  task automatic run_op(input int a, input int b, input int op, input int sh,
                        input int mask, input logic [31:0] x,
                        output logic [31:0] d, output logic z, output logic n);
    @(negedge clk);
    put(a, b, op, sh, mask, x);
    #1;
    while (!uop_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
    @(negedge clk);
    d = wb_data;
    z = wb_zero;
    n = wb_neg;
  endtask

  task automatic read_reg(input int idx, output logic [31:0] d);
    logic z, n;
    run_op(idx, B_ZERO, OP_PASSA, 0, 0, 32'h0, d, z, n);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 ready after reset", {31'b0, uop_ready}, 32'd1);
    chk("R1 wb_valid after reset", {31'b0, wb_valid}, 32'd0);
    read_reg(3, d);
    chk("R1 r3 zero", d, 32'h0);
    read_reg(7, d);
    chk("R1 r7 zero", d, 32'h0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    put(0, B_EXT, OP_PASSB, 0, 0, 32'h0000_0055);
    #1 chk("R2 ready", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    idle();
    chk("R2 no wb after one edge", {31'b0, wb_valid}, 32'd0);
    @(negedge clk);
    chk("R2 wb after two edges", {31'b0, wb_valid}, 32'd1);
    chk("R2 wb data", wb_data, 32'h0000_0055);
    @(negedge clk);
    chk("R2 wb single cycle", {31'b0, wb_valid}, 32'd0);
  endtask

  task automatic t_alu();
    logic [31:0] d;
    logic z, n;
    run_op(0, B_EXT, OP_PASSB, 0, 8'h02, V1, d, z, n);
    run_op(0, B_EXT, OP_PASSB, 0, 8'h04, V2, d, z, n);
    run_op(1, 2, OP_ADD, 0, 0, 0, d, z, n);   chk("R3 add", d, V1 + V2);
    run_op(1, 2, OP_SUB, 0, 0, 0, d, z, n);   chk("R3 sub", d, V1 - V2);
    run_op(1, 2, OP_AND, 0, 0, 0, d, z, n);   chk("R3 and", d, V1 & V2);
    run_op(1, 2, OP_OR, 0, 0, 0, d, z, n);    chk("R3 or", d, V1 | V2);
    run_op(1, 2, OP_INCB, 0, 0, 0, d, z, n);  chk("R3 incb", d, V2 + 32'd1);
    run_op(1, 2, OP_DECB, 0, 0, 0, d, z, n);  chk("R3 decb", d, V2 - 32'd1);
    run_op(1, 2, OP_PASSA, 0, 0, 0, d, z, n); chk("R3 passa", d, V1);
    run_op(1, 2, OP_PASSB, 0, 0, 0, d, z, n); chk("R3 passb", d, V2);
  endtask

  task automatic t_shift();
    logic [31:0] d;
    logic z, n;
    run_op(0, B_EXT, OP_PASSB, 1, 0, 32'h8000_0010, d, z, n);
    chk("R4 sll8", d, 32'h0000_1000);
    run_op(0, B_EXT, OP_PASSB, 2, 0, 32'h8000_0010, d, z, n);
    chk("R4 sra1", d, 32'hC000_0008);
    run_op(0, B_EXT, OP_PASSB, 3, 0, 32'h8000_0010, d, z, n);
    chk("R4 code3 unchanged", d, 32'h8000_0010);
    run_op(1, 2, OP_ADD, 2, 0, 0, d, z, n);
    chk("R4 shift after alu", d, (V1 + V2) >> 1);
  endtask

  task automatic t_bsel();
    logic [31:0] d;
    logic z, n;
    run_op(0, B_EXT, OP_PASSB, 0, 0, 32'hDEAD_BEEF, d, z, n);
    chk("R5 code8 ext", d, 32'hDEAD_BEEF);
    run_op(0, 9, OP_PASSB, 0, 0, 32'hFFFF_FFFF, d, z, n);
    chk("R5 code9 zero", d, 32'h0);
    run_op(0, 15, OP_PASSB, 0, 0, 32'hFFFF_FFFF, d, z, n);
    chk("R5 code15 zero", d, 32'h0);
    run_op(0, 2, OP_PASSB, 0, 0, 32'hFFFF_FFFF, d, z, n);
    chk("R5 code2 reg", d, V2);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    logic z, n;
    run_op(1, 1, OP_SUB, 0, 0, 0, d, z, n);
    chk("R6 zero flag set", {31'b0, z}, 32'd1);
    chk("R6 neg flag clear", {31'b0, n}, 32'd0);
    run_op(0, B_ZERO, OP_DECB, 0, 0, 0, d, z, n);
    chk("R6 decb wrap", d, 32'hFFFF_FFFF);
    chk("R6 neg flag set", {31'b0, n}, 32'd1);
    chk("R6 zero flag clear", {31'b0, z}, 32'd0);
    run_op(0, B_EXT, OP_PASSB, 1, 0, 32'h0100_0000, d, z, n);
    chk("R6 zero after shift", {31'b0, z}, 32'd1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    logic z, n;
    run_op(0, B_EXT, OP_PASSB, 0, 8'b1001_0001, 32'h0000_00A5, d, z, n);
    read_reg(0, d); chk("R7 r0 written", d, 32'h0000_00A5);
    read_reg(4, d); chk("R7 r4 written", d, 32'h0000_00A5);
    read_reg(7, d); chk("R7 r7 written", d, 32'h0000_00A5);
    read_reg(1, d); chk("R7 r1 untouched", d, V1);
    run_op(0, B_EXT, OP_PASSB, 0, 0, 32'h7777_7777, d, z, n);
    read_reg(4, d); chk("R7 zero mask writes none", d, 32'h0000_00A5);
  endtask

  task automatic t_stream();
    int seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (wb_valid) seen++;
      if (k < 4) begin
        if (k == 0) put(1, 2, OP_ADD, 0, 8'h08, 0);
        else        put(1, 2, OP_OR, 0, 0, 0);
        #1 chk("R8 ready in stream", {31'b0, uop_ready}, 32'd1);
      end else begin
        idle();
      end
    end
    chk("R8 consecutive results", 32'(seen), 32'd4);
  endtask

  task automatic t_hazard();
    logic [31:0] d;
    @(negedge clk);
    put(0, B_EXT, OP_PASSB, 0, 8'h20, 32'd7);
    #1 chk("R9 producer ready", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    put(0, 5, OP_INCB, 0, 8'h40, 0);
    #1 chk("R9 back-to-back stall 1", {31'b0, uop_ready}, 32'd0);
    @(negedge clk);
    #1 chk("R9 back-to-back stall 2", {31'b0, uop_ready}, 32'd0);
    @(negedge clk);
    #1 chk("R9 back-to-back release", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    idle();
    read_reg(6, d);
    chk("R9 consumer saw producer", d, 32'd8);

    @(negedge clk);
    put(0, B_EXT, OP_PASSB, 0, 8'h20, 32'd9);
    @(negedge clk);
    put(1, 2, OP_ADD, 0, 0, 0);
    #1 chk("R9 independent between", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    put(0, 5, OP_INCB, 0, 8'h80, 0);
    #1 chk("R9 gap stall", {31'b0, uop_ready}, 32'd0);
    @(negedge clk);
    #1 chk("R9 gap release", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    idle();
    read_reg(7, d);
    chk("R9 gap consumer value", d, 32'd10);
  endtask

  task automatic t_unused();
    logic [31:0] d;
    @(negedge clk);
    put(0, B_EXT, OP_PASSB, 0, 8'h08, 32'h33);
    @(negedge clk);
    put(3, B_EXT, OP_PASSB, 0, 0, 32'h1);
    #1 chk("R10 A ignored by passb", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    put(1, 3, OP_PASSA, 0, 0, 0);
    #1 chk("R10 B ignored by passa", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    put(3, B_EXT, OP_INCB, 0, 0, 32'h1);
    #1 chk("R10 A ignored by incb", {31'b0, uop_ready}, 32'd1);
    @(negedge clk);
    idle();
    @(negedge clk);
    put(0, B_EXT, OP_PASSB, 0, 8'h08, 32'h44);
    @(negedge clk);
    put(3, B_ZERO, OP_PASSA, 0, 0, 0);
    #1 chk("R10 used A still stalls", {31'b0, uop_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    read_reg(3, d);
    chk("R10 r3 final", d, 32'h44);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    put(0, 0, 0, 0, 0, 0);
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_latency();
    t_alu();
    t_shift();
    t_bsel();
    t_flags();
    t_mask();
    t_stream();
    t_hazard();
    t_unused();
    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule